// File: doc/BRIEF.md
# Two-Channel Interleaved Match Correlator

This block counts, for each of two independent sample streams, how many of the four most recent samples of that stream equal four programmed reference values. The two streams share one port and one datapath. Their samples alternate cycle by cycle, and each sample carries a channel tag. Every state element of the single-stream correlator is doubled. The history line therefore holds both streams side by side, and the position two steps back always holds the same channel's previous sample. The comparators and the two-level adder tree are pipelined so that the longest combinational path is one small addition.

Results leave the block interleaved in the same way as the inputs, each with the tag of the sample that produced it. If the tag sequence breaks, the block raises a one-cycle error flag and drops the offending sample, so the histories of the two channels cannot mix. Cycles without a valid sample leave all state untouched. The tap count and the number of interleaved channels are parameters. The defaults are four taps and two channels. A parameter selects whether equal or unequal samples are counted.

Top module: `cslow_correlator`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, out_valid and err_order are low.
- R2: For an accepted sample x of channel c, out_count equals the number of taps k in 0..3 for which the k-th most recent accepted sample of channel c (k=0 being x itself) equals the reference held in coef bits [k*W +: W].
- R3: The result for a sample accepted at clock edge n appears with out_valid high after edge n+2. This is a latency of three cycles from the input cycle.
- R4: out_chan on a valid result equals the tag of the sample that produced it. Successive valid results rotate through the channels in order.
- R5: out_valid stays low for the first three accepted samples of each channel after reset (the first six accepted samples overall). It is high for every later accepted sample.
- R6: After reset the expected tag is 0. Each accepted sample advances the expected tag by one, wrapping from 1 to 0.
- R7: A valid sample whose tag differs from the expected tag raises err_order for exactly the next cycle. It produces no result and changes neither the histories nor the expected tag.
- R8: A cycle with in_valid low changes no history, no expected tag and no fill state, and it produces no result.
- R9: out_count never exceeds 4. It reaches 4 when all four taps match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample present this cycle |
| in_chan | input | CHW (1) | Channel tag of the sample |
| in_sample | input | W (8) | Sample value |
| coef | input | TAPS*W (32) | Reference values, tap k in bits [k*W +: W] |
| out_valid | output | 1 | Result present this cycle |
| out_chan | output | CHW (1) | Channel tag of the result |
| out_count | output | SW (3) | Number of matching taps |
| err_order | output | 1 | Previous cycle's sample broke tag order and was dropped |

## Verification
On every cycle, the assertions check that the expected tag rotates on each accepted sample, that idle cycles freeze the tag, the fill state and the newest history slot, and that no count exceeds the tap total. They also check that an error flag always follows a valid input, and that valid results come out in channel rotation. Only the bench's scenarios can show the counts themselves against a per-channel model, along with the exact three-cycle latency, the six-sample fill after each reset, and the fact that a dropped sample leaves no trace in later counts. The bench sweeps a 2-bit sample width so that matches are frequent and every count from 0 to 4 appears. It mixes idle cycles and wrong tags into the stream, changes the references while samples are in flight, and resets in the middle of the stream.

// File: rtl/cslow_corr_pkg.sv
package cslow_corr_pkg;

   // width of a channel tag; at least one bit
   function automatic int chan_bits(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   // width able to hold a count from 0 to taps
   function automatic int count_bits(input int taps);
      return $clog2(taps + 1);
   endfunction

endpackage

// File: rtl/cslow_chan_seq.sv
module cslow_chan_seq
   import cslow_corr_pkg::*;
#(
   parameter int NCH  = 2,
   parameter int TAPS = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       in_valid,
   input  logic [chan_bits(NCH)-1:0]  in_chan,
   output logic                       accept,
   output logic                       hist_full,
   output logic                       err_order
);
   localparam int CHW  = chan_bits(NCH);
   localparam int FILL = NCH * (TAPS - 1);
   localparam int FW   = $clog2(FILL + 1);

   logic [CHW-1:0] exp_chan;
   logic [FW-1:0]  fill_cnt;
   logic           tag_ok;

   assign tag_ok    = (in_chan == exp_chan);
   assign accept    = in_valid && tag_ok;
   assign hist_full = (fill_cnt == FW'(FILL));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exp_chan  <= '0;
         fill_cnt  <= '0;
         err_order <= 1'b0;
      end else begin
         err_order <= in_valid && !tag_ok;
         if (accept) begin
            exp_chan <= (exp_chan == CHW'(NCH - 1)) ? '0 : exp_chan + 1'b1;
            if (!hist_full)
               fill_cnt <= fill_cnt + 1'b1;
         end
      end
   end

   AST_TAG_ROTATES: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (exp_chan != $past(exp_chan))); // R6

   AST_IDLE_FREEZES_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(exp_chan) && $stable(fill_cnt))); // R8

endmodule

// File: rtl/cslow_tap_line.sv
module cslow_tap_line
   import cslow_corr_pkg::*;
#(
   parameter int W           = 8,
   parameter int NCH         = 2,
   parameter int TAPS        = 4,
   parameter bit COUNT_EQUAL = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       accept,
   input  logic                       hist_full,
   input  logic [chan_bits(NCH)-1:0]  chan,
   input  logic [W-1:0]               sample,
   input  logic [TAPS*W-1:0]          coef,
   output logic                       m_valid,
   output logic [chan_bits(NCH)-1:0]  m_chan,
   output logic [TAPS-1:0]            m_bits
);
   localparam int CHW   = chan_bits(NCH);
   localparam int DEPTH = NCH * (TAPS - 1);

   // doubled history: slot k*NCH-1 holds the same channel's k-th older sample
   logic [W-1:0]    sr [DEPTH];
   logic [TAPS-1:0] hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) sr[i] <= '0;
      end else if (accept) begin
         sr[0] <= sample;
         for (int i = 1; i < DEPTH; i++) sr[i] <= sr[i-1];
      end
   end

   for (genvar k = 0; k < TAPS; k++) begin : g_tap
      logic [W-1:0] tv;
      if (k == 0) begin : g_now
         assign tv = sample;
      end else begin : g_old
         assign tv = sr[k*NCH-1];
      end
      if (COUNT_EQUAL) begin : g_eq
         assign hit[k] = (tv == coef[k*W +: W]);
      end else begin : g_ne
         assign hit[k] = (tv != coef[k*W +: W]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_valid <= 1'b0;
         m_chan  <= '0;
         m_bits  <= '0;
      end else begin
         m_valid <= accept && hist_full;
         if (accept) begin
            m_chan <= chan;
            m_bits <= hit;
         end
      end
   end

   AST_IDLE_FREEZES_HIST: assert property (@(posedge clk) disable iff (!rst_n)
      !accept |=> $stable(sr[0])); // R8

   logic [CHW-1:0] unused_width_probe;
   assign unused_width_probe = '0;

endmodule

// File: rtl/cslow_add_tree.sv
module cslow_add_tree
   import cslow_corr_pkg::*;
#(
   parameter int NCH  = 2,
   parameter int TAPS = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        in_vld,
   input  logic [chan_bits(NCH)-1:0]   in_chan,
   input  logic [TAPS-1:0]             in_bits,
   output logic                        out_vld,
   output logic [chan_bits(NCH)-1:0]   out_chan,
   output logic [count_bits(TAPS)-1:0] out_sum
);
   localparam int CHW = chan_bits(NCH);
   localparam int SW  = count_bits(TAPS);
   localparam int LVL = $clog2(TAPS);

   for (genvar l = 0; l <= LVL; l++) begin : g_lvl
      localparam int N = TAPS >> l;
      logic [SW-1:0]  sum [N];
      logic           vld;
      logic [CHW-1:0] chan;
      if (l == 0) begin : g_leaf
         for (genvar i = 0; i < N; i++) begin : g_bit
            assign sum[i] = SW'(in_bits[i]);
         end
         assign vld  = in_vld;
         assign chan = in_chan;
      end else begin : g_node
         // one register rank per level: the deepest path is a single adder
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld  <= 1'b0;
               chan <= '0;
               for (int i = 0; i < N; i++) sum[i] <= '0;
            end else begin
               vld <= g_lvl[l-1].vld;
               if (g_lvl[l-1].vld) begin
                  chan <= g_lvl[l-1].chan;
                  for (int i = 0; i < N; i++)
                     sum[i] <= g_lvl[l-1].sum[2*i] + g_lvl[l-1].sum[2*i+1];
               end
            end
         end
      end
   end

   assign out_vld  = g_lvl[LVL].vld;
   assign out_chan = g_lvl[LVL].chan;
   assign out_sum  = g_lvl[LVL].sum[0];

   AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> (out_sum <= SW'(TAPS))); // R9

endmodule

// File: rtl/cslow_correlator.sv
module cslow_correlator
   import cslow_corr_pkg::*;
#(
   parameter int W           = 8,
   parameter int NCH         = 2,
   parameter int TAPS        = 4,
   parameter bit COUNT_EQUAL = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        in_valid,
   input  logic [chan_bits(NCH)-1:0]   in_chan,
   input  logic [W-1:0]                in_sample,
   input  logic [TAPS*W-1:0]           coef,
   output logic                        out_valid,
   output logic [chan_bits(NCH)-1:0]   out_chan,
   output logic [count_bits(TAPS)-1:0] out_count,
   output logic                        err_order
);
   localparam int CHW = chan_bits(NCH);
   localparam int SW  = count_bits(TAPS);

   if (W < 1) begin : g_bad_w
      $error("sample width must be at least 1");
   end
   if (NCH < 2) begin : g_bad_nch
      $error("at least two interleaved channels are required");
   end
   if (TAPS < 2 || (1 << $clog2(TAPS)) != TAPS) begin : g_bad_taps
      $error("tap count must be a power of two, at least 2");
   end

   logic           accept;
   logic           hist_full;
   logic           m_valid;
   logic [CHW-1:0] m_chan;
   logic [TAPS-1:0] m_bits;

   cslow_chan_seq #(.NCH(NCH), .TAPS(TAPS)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_chan   (in_chan),
      .accept    (accept),
      .hist_full (hist_full),
      .err_order (err_order)
   );

   cslow_tap_line #(.W(W), .NCH(NCH), .TAPS(TAPS), .COUNT_EQUAL(COUNT_EQUAL)) u_taps (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .hist_full (hist_full),
      .chan      (in_chan),
      .sample    (in_sample),
      .coef      (coef),
      .m_valid   (m_valid),
      .m_chan    (m_chan),
      .m_bits    (m_bits)
   );

   cslow_add_tree #(.NCH(NCH), .TAPS(TAPS)) u_tree (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_vld   (m_valid),
      .in_chan  (m_chan),
      .in_bits  (m_bits),
      .out_vld  (out_valid),
      .out_chan (out_chan),
      .out_sum  (out_count)
   );

   // checker state: tag of the last valid result since reset
   logic [CHW-1:0] chk_last;
   logic           chk_seen;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chk_last <= '0;
         chk_seen <= 1'b0;
      end else if (out_valid) begin
         chk_last <= out_chan;
         chk_seen <= 1'b1;
      end
   end

   AST_RESULT_ROTATES: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && chk_seen) |->
         (out_chan == ((chk_last == CHW'(NCH - 1)) ? '0 : chk_last + 1'b1))); // R4

   AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      err_order |-> $past(in_valid)); // R7

   logic [SW-1:0] unused_sw_probe;
   assign unused_sw_probe = '0;

endmodule

// File: tb/cslow_correlator_tb.sv
module cslow_correlator_tb;
   localparam int CLK_NS = 10;
   localparam int W      = 2;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [0:0]   in_chan = '0;
   logic [W-1:0] in_sample = '0;
   logic [4*W-1:0] coef;
   logic         out_valid;
   logic [0:0]   out_chan;
   logic [2:0]   out_count;
   logic         err_order;

   logic [W-1:0] a [4];
   logic [W-1:0] a_next [4];
   assign coef = {a[3], a[2], a[1], a[0]};

   always #(CLK_NS/2) clk = ~clk;

   cslow_correlator #(.W(W), .NCH(2), .TAPS(4)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_chan(in_chan),
      .in_sample(in_sample), .coef(coef), .out_valid(out_valid),
      .out_chan(out_chan), .out_count(out_count), .err_order(err_order)
   );

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   logic       ev [8];
   logic       ec [8];
   logic [2:0] eq [8];
   logic       ee [8];
   logic [W-1:0] hist [2][3];
   int  hcnt [2];
   logic nc;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   task automatic model_clear();
      for (int i = 0; i < 8; i++) begin ev[i] = 0; ec[i] = 0; eq[i] = 0; ee[i] = 0; end
      for (int c = 0; c < 2; c++) begin
         hcnt[c] = 0;
         for (int k = 0; k < 3; k++) hist[c][k] = '0;
      end
      nc = 1'b0;
   endtask

   task automatic step(input bit v, input bit c, input logic [W-1:0] x);
      int s;
      int n;
      int t;
      @(negedge clk);
      cyc++;
      s = cyc % 8;
      check(out_valid === ev[s], "R3 R5 R8 out_valid", int'(out_valid), int'(ev[s]));
      if (ev[s] && out_valid) begin
         check(out_chan === ec[s], "R4 out_chan", int'(out_chan), int'(ec[s]));
         check(out_count === eq[s], "R2 R9 out_count", int'(out_count), int'(eq[s]));
      end
      check(err_order === ee[s], "R6 R7 err_order", int'(err_order), int'(ee[s]));
      ev[s] = 0; ee[s] = 0;
      for (int k = 0; k < 4; k++) a[k] = a_next[k];
      in_valid  = v;
      in_chan   = c;
      in_sample = x;
      if (v) begin
         if (c != nc) begin
            ee[(cyc + 1) % 8] = 1'b1;
         end else begin
            if (hcnt[c] >= 3) begin
               n = (x == a[0]) ? 1 : 0;
               for (int k = 1; k < 4; k++) n += (hist[c][k-1] == a[k]) ? 1 : 0;
               t = (cyc + 3) % 8;
               ev[t] = 1'b1; ec[t] = c; eq[t] = 3'(n);
            end
            hist[c][2] = hist[c][1];
            hist[c][1] = hist[c][0];
            hist[c][0] = x;
            hcnt[c]++;
            nc = ~nc;
         end
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      in_valid = 1'b0;
      repeat (2) begin
         @(negedge clk);
         check(out_valid === 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
         check(err_order === 1'b0, "R1 err_order in reset", int'(err_order), 0);
      end
      model_clear();
      rst_n = 1'b1;
   endtask

   initial begin
      #(CLK_NS * 200000);
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      for (int k = 0; k < 4; k++) begin a[k] = W'(k); a_next[k] = W'(k); end
      model_clear();
      do_reset();
      // R1: first cycle after release stays quiet
      step(1'b0, 1'b0, '0);
      // R6 R7: a channel-1 sample first is flagged and dropped
      step(1'b1, 1'b1, 2'd3);
      step(1'b0, 1'b0, '0);
      // R5: exact fill, no gaps
      for (int i = 0; i < 16; i++) step(1'b1, 1'(i % 2), W'(i / 2));
      // R2 R8 R7: random mix of idles, bad tags and reference changes
      for (int i = 0; i < 1200; i++) begin
         int r;
         bit v;
         bit c;
         if (i % 150 == 0)
            for (int k = 0; k < 4; k++) a_next[k] = W'($urandom_range(0, 3));
         r = $urandom_range(0, 99);
         v = (r < 85);
         c = nc;
         if (r < 6) c = ~nc;
         step(v, c, W'($urandom_range(0, 3)));
      end
      // R9: every tap matches, count 4
      for (int k = 0; k < 4; k++) a_next[k] = 2'd1;
      for (int i = 0; i < 12; i++) step(1'b1, nc, 2'd1);
      // R2: nothing matches, count 0
      for (int k = 0; k < 4; k++) a_next[k] = 2'd2;
      for (int i = 0; i < 12; i++) step(1'b1, nc, 2'd0);
      // R1 R5: reset with results in flight, then refill
      do_reset();
      for (int i = 0; i < 20; i++) step(1'b1, nc, W'(i % 4));
      for (int i = 0; i < 4; i++) step(1'b0, 1'b0, '0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule